// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the decision stage of an eight-line interrupt controller. It receives the current pending-request vector, the mask register, the in-service register, a rotation offset and three mode flags. It decides whether a new interrupt should be signalled to the processor side, and if so which line. Request capture, the register interface and the acknowledge sequence sit in neighbouring blocks. Those blocks feed this one and consume its two outputs.

Priority rotates. The line named by the offset is the most urgent, the next line up is second, and so on, wrapping past the top line back to line 0. A pending, unmasked request is reported only if it ranks strictly above the most urgent line currently in service. Two mode flags can hide some in-service bits from that comparison: one hides lines that are masked, and the other hides the cascade line on a primary controller.

All decisions are registered. The outputs show the inputs seen at the previous rising clock edge. No data stream passes through the block, so every pin is a plain level with no valid/ready handshake and no back-pressure.

Top module: `irq_rank_resolver`

## Requirements
- R1: While `rst_n` is low, `irq_o` is 0 and `line_o` is 0.
- R2: Bit i of every vector is line i. The candidate set is `req_i & ~mask_i`. A line whose mask bit is 1 is never reported.
- R3: With no line in service, the reported line is the first candidate met when walking from line `rot_i` upward, wrapping from 7 to 0. `line_o` carries this absolute line number, not its rank.
- R4: When the candidate set is empty, `irq_o` is 0.
- R5: Rank r is the distance from `rot_i` walking upward modulo 8, and a lower rank is more urgent. A candidate is reported only if its rank is strictly lower than the rank of the most urgent in-service line. A candidate of equal or lower urgency leaves `irq_o` at 0.
- R6: When `smask_i` is 1, in-service lines whose mask bit is 1 take no part in the comparison of R5.
- R7: When both `nested_i` and `primary_i` are 1, in-service bit 2 (the cascade line) takes no part in the comparison of R5. If either flag is 0, bit 2 takes part like any other line.
- R8: Outputs are registered. A change on any input shows on `irq_o` and `line_o` exactly one rising edge later, and never before that edge.
- R9: When `irq_o` is 0, `line_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Pending request vector, bit i = line i |
| mask_i | input | 8 | Mask register, 1 = line masked |
| insvc_i | input | 8 | In-service vector, bit i = line i |
| rot_i | input | 3 | Rotation offset: the most urgent line |
| smask_i | input | 1 | Special-mask mode: masked lines leave the in-service comparison |
| nested_i | input | 1 | Fully nested cascade mode |
| primary_i | input | 1 | 1 = this controller is the primary of a cascade |
| irq_o | output | 1 | Interrupt request and valid flag for `line_o` |
| line_o | output | 3 | Selected absolute line number |

## Verification
The assertions assume that every input is synchronous to `clk` and holds steady across each rising edge. This lets the previous-cycle value of an input be treated as exactly the value the output registers sampled. The offset is taken to be below the line count, which holds for every value at the default of eight lines. The bench changes inputs only on the falling edge. It runs directed cases for the rotation wrap, ties with the in-service rank and each mode flag, and then a long phase of free random vectors, so the assumptions hold throughout.

// File: rtl/irq_rank_pkg.sv
package irq_rank_pkg;
  localparam int unsigned DEF_LINES = 8;
  localparam int unsigned DEF_CASC  = 2;

  typedef struct packed {
    logic smask;
    logic nested;
    logic primary;
  } rank_mode_t;
endpackage

// File: rtl/irq_rank_search.sv
module irq_rank_search #(
  parameter int unsigned NLINES = 8,
  localparam int unsigned LW = $clog2(NLINES),
  localparam int unsigned RW = LW + 1
) (
  input  logic [NLINES-1:0] vec_i,
  input  logic [LW-1:0]     rot_i,
  output logic [RW-1:0]     rank_o
);
  // Walk from the least urgent rank down so that the most urgent hit wins.
  always_comb begin
    int idx;
    rank_o = RW'(NLINES);
    for (int i = NLINES - 1; i >= 0; i--) begin
      idx = i + int'(rot_i);
      if (idx >= int'(NLINES)) idx = idx - int'(NLINES);
      if (vec_i[idx]) rank_o = RW'(i);
    end
  end
endmodule

// File: rtl/irq_insvc_filter.sv
module irq_insvc_filter
  import irq_rank_pkg::*;
#(
  parameter int unsigned NLINES = 8,
  parameter int unsigned CASC   = 2
) (
  input  logic [NLINES-1:0] insvc_i,
  input  logic [NLINES-1:0] mask_i,
  input  rank_mode_t        mode_i,
  output logic [NLINES-1:0] eff_o
);
  logic [NLINES-1:0] casc_hide;

  always_comb begin
    casc_hide = '0;
    if (mode_i.nested && mode_i.primary) casc_hide[CASC] = 1'b1;
  end

  always_comb begin
    eff_o = insvc_i & ~casc_hide;
    if (mode_i.smask) eff_o = eff_o & ~mask_i;
  end
endmodule

// File: rtl/irq_rank_resolver.sv
module irq_rank_resolver
  import irq_rank_pkg::*;
#(
  parameter int unsigned NLINES = DEF_LINES,
  parameter int unsigned CASC   = DEF_CASC,
  localparam int unsigned LW = $clog2(NLINES),
  localparam int unsigned RW = LW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] req_i,
  input  logic [NLINES-1:0] mask_i,
  input  logic [NLINES-1:0] insvc_i,
  input  logic [LW-1:0]     rot_i,
  input  logic              smask_i,
  input  logic              nested_i,
  input  logic              primary_i,
  output logic              irq_o,
  output logic [LW-1:0]     line_o
);
  logic [NLINES-1:0] cand;
  logic [NLINES-1:0] eff_is;
  logic [RW-1:0]     req_rank;
  logic [RW-1:0]     cur_rank;
  logic              win;
  logic [LW-1:0]     abs_line;
  rank_mode_t        mode;

  assign cand = req_i & ~mask_i;
  assign mode = '{smask: smask_i, nested: nested_i, primary: primary_i};

  irq_rank_search #(.NLINES(NLINES)) u_req_search (
    .vec_i (cand),
    .rot_i (rot_i),
    .rank_o(req_rank)
  );

  irq_insvc_filter #(.NLINES(NLINES), .CASC(CASC)) u_filter (
    .insvc_i(insvc_i),
    .mask_i (mask_i),
    .mode_i (mode),
    .eff_o  (eff_is)
  );

  irq_rank_search #(.NLINES(NLINES)) u_cur_search (
    .vec_i (eff_is),
    .rot_i (rot_i),
    .rank_o(cur_rank)
  );

  // An empty candidate set gives rank NLINES, which is never below cur_rank.
  assign win = (req_rank < cur_rank);

  always_comb begin
    int s;
    s = int'(req_rank[LW-1:0]) + int'(rot_i);
    if (s >= int'(NLINES)) s = s - int'(NLINES);
    abs_line = LW'(s);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o  <= 1'b0;
      line_o <= '0;
    end else begin
      irq_o  <= win;
      line_o <= win ? abs_line : '0;
    end
  end

  // R2
  cand_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (($past(cand) & (NLINES'(1) << line_o)) != '0));

  // R4
  empty_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cand) == '0) |-> !irq_o);

  // R5
  top_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(eff_is[rot_i]) |-> !irq_o);

  // R9
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_o |-> (line_o == '0));
endmodule

// File: tb/irq_rank_resolver_tb_top.sv
module irq_rank_resolver_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_i = '0, mask_i = '0, insvc_i = '0;
  logic [2:0] rot_i = '0;
  logic       smask_i = 1'b0, nested_i = 1'b0, primary_i = 1'b0;
  logic       irq_o;
  logic [2:0] line_o;

  int checks = 0;
  int errors = 0;
  bit exp_irq = 1'b0;
  int exp_line = 0;
  string exp_tag = "R1";

  always #4 clk = ~clk;

  irq_rank_resolver dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_i(mask_i),
    .insvc_i(insvc_i), .rot_i(rot_i), .smask_i(smask_i),
    .nested_i(nested_i), .primary_i(primary_i),
    .irq_o(irq_o), .line_o(line_o)
  );

  // Behavioural reference: rank of first set bit walking from rot upward.
  function automatic int rank_of(int v, int rot);
    for (int p = 0; p < 8; p++)
      if (((v >> ((p + rot) % 8)) & 1) == 1) return p;
    return 8;
  endfunction

  task automatic compute();
    int c, e, rr, cr;
    c = int'(req_i & ~mask_i);
    e = int'(insvc_i);
    if (smask_i) e = e & ~int'(mask_i);
    if (nested_i && primary_i) e = e & ~4;
    rr = rank_of(c, int'(rot_i));
    cr = rank_of(e, int'(rot_i));
    exp_irq  = (rr < cr);
    exp_line = exp_irq ? (rr + int'(rot_i)) % 8 : 0;
  endtask

  task automatic check(string tag);
    checks++;
    if (irq_o !== exp_irq || int'(line_o) !== exp_line) begin
      errors++;
      $display("FAIL %s: irq=%0b line=%0d expected irq=%0b line=%0d",
               tag, irq_o, line_o, exp_irq, exp_line);
    end
  endtask

  task automatic apply(input logic [7:0] rq, input logic [7:0] mk,
                       input logic [7:0] is, input logic [2:0] rt,
                       input bit sm, input bit ne, input bit pr, input string tag);
    @(negedge clk);
    check(exp_tag);
    req_i = rq; mask_i = mk; insvc_i = is; rot_i = rt;
    smask_i = sm; nested_i = ne; primary_i = pr;
    #1;
    check("R8");  // new inputs must not show before the next rising edge
    compute();
    exp_tag = tag;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    req_i = 8'hFF; insvc_i = 8'h00; rot_i = 3'd3;
    repeat (3) @(negedge clk);
    exp_irq = 1'b0; exp_line = 0;
    check("R1");
    rst_n = 1'b1;
    compute();
    exp_tag = "R3";

    // R3 rotation and wrap
    apply(8'h21, 8'h00, 8'h00, 3'd5, 0, 0, 0, "R3");
    apply(8'h11, 8'h00, 8'h00, 3'd5, 0, 0, 0, "R3");
    apply(8'h80, 8'h00, 8'h00, 3'd0, 0, 0, 0, "R3");
    apply(8'h81, 8'h00, 8'h00, 3'd1, 0, 0, 0, "R3");
    // R2 masking
    apply(8'h03, 8'h01, 8'h00, 3'd0, 0, 0, 0, "R2");
    apply(8'h03, 8'h03, 8'h00, 3'd0, 0, 0, 0, "R2");
    // R4 empty
    apply(8'h00, 8'h00, 8'h00, 3'd4, 0, 0, 0, "R4");
    // R5 strict comparison
    apply(8'h08, 8'h00, 8'h08, 3'd0, 0, 0, 0, "R5");
    apply(8'h04, 8'h00, 8'h08, 3'd0, 0, 0, 0, "R5");
    apply(8'h10, 8'h00, 8'h08, 3'd0, 0, 0, 0, "R5");
    apply(8'h01, 8'h00, 8'h80, 3'd7, 0, 0, 0, "R5");
    // R6 special mask
    apply(8'h08, 8'h02, 8'h02, 3'd0, 0, 0, 0, "R6");
    apply(8'h08, 8'h02, 8'h02, 3'd0, 1, 0, 0, "R6");
    // R7 cascade line ignored only when nested on a primary
    apply(8'h08, 8'h00, 8'h04, 3'd0, 0, 1, 1, "R7");
    apply(8'h08, 8'h00, 8'h04, 3'd0, 0, 1, 0, "R7");
    apply(8'h08, 8'h00, 8'h04, 3'd0, 0, 0, 1, "R7");
    apply(8'h04, 8'h00, 8'h04, 3'd0, 0, 1, 1, "R7");
    // R9 line returns to zero once idle
    apply(8'h40, 8'h00, 8'h00, 3'd0, 0, 0, 0, "R9");
    apply(8'h40, 8'h40, 8'h00, 3'd0, 0, 0, 0, "R9");

    for (int k = 0; k < 3000; k++) begin
      apply(8'($urandom), 8'($urandom & $urandom), 8'($urandom & $urandom),
            3'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), "R5");
    end
    @(negedge clk);
    check(exp_tag);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule